// File: doc/BRIEF.md
# Observability Signature Chain

This block is a 24-stage register that watches a word of internal nodes and folds it into a signature, or serves as a plain serial scan register. A single bank of flops does both jobs. In compression mode every stage takes its lower neighbour XOR its own node input, and the bit falling off the top is fed back into a fixed set of tap stages. That makes the register divide the node stream by the polynomial x^24+x^23+x^22+x^17+1, one step per clock at full speed. The bit falling off the top is the quotient bit of that division.

Three uses are supported.
- **On-line compression.** Separate pulses switch it on and off. While it runs, the block emits the quotient bit on a dedicated output every cycle.
- **Snapshot.** A pulse folds the nodes in for exactly one cycle. The block then shifts the whole register out automatically, most significant bit first, with a valid flag over the 24 bit times.
- **Manual shift.** An enable shifts the register while it is idle, for loading a seed or reading it back.

A synchronous clear zeroes the register before a signature run.

Top module: `obl_sig_chain`

## Requirements
- R1: After reset the register is all zeros, no mode is active, and scan_out, scan_vld, q_bit and q_vld are all 0.
- R2: When clr is high, the register holds all zeros after that edge, whatever else is requested in the same cycle. The mode and the shift-out sequence are not changed by clr.
- R3: A compression step sets stage i to stage i-1 XOR nodes[i], with stage 0 receiving 0 from below. When stage 23 (the quotient bit) was 1, stages 0, 17, 22 and 23 are additionally inverted.
- R4: A comp_on pulse while idle starts on-line compression from the next cycle. A comp_off pulse during on-line compression stops it from the next cycle. comp_on has no effect while compression is already running.
- R5: During on-line compression, q_vld is 1 and q_bit equals stage 23 in every cycle, and the register takes one compression step per cycle. Outside on-line compression both outputs are 0.
- R6: A snap_go pulse while idle or compressing performs exactly one compression step in that cycle. scan_vld is then 1 for exactly 24 cycles while scan_out presents the snapshot most significant bit first. After that the block is idle with compression off.
- R7: While the snapshot is being shifted out, comp_on, comp_off, snap_go, scan_en and nodes have no effect, and scan_in enters stage 0 each cycle.
- R8: When idle with scan_en high, the register shifts one place toward stage 23 per cycle and scan_in enters stage 0. nodes are ignored, and scan_out always shows stage 23.
- R9: When idle with no request, the register holds its value.
- R10: When snap_go and comp_on arrive together while idle, the snapshot is taken and compression does not start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of the register |
| comp_on | input | 1 | Pulse: start on-line compression |
| comp_off | input | 1 | Pulse: stop on-line compression |
| snap_go | input | 1 | Pulse: one-cycle capture, then automatic shift-out |
| scan_en | input | 1 | Manual shift enable while idle |
| scan_in | input | 1 | Serial data into stage 0 |
| nodes | input | 24 | Observed internal nodes, one per stage |
| scan_out | output | 1 | Stage 23 (serial output) |
| scan_vld | output | 1 | High while a snapshot bit is on scan_out |
| q_bit | output | 1 | Quotient bit during on-line compression |
| q_vld | output | 1 | High during on-line compression |

## Verification
The properties assume that snap_go is the only way a shift-out can start. They also assume that, whenever the register is idle with no request pending, nothing but clr or scan_en may move it, which lets a quiet cycle be checked as a hold. The random stimulus uses only the pins listed above and keeps clr rare, so that complete snapshot dumps and long compression runs occur often. Requests that arrive during a dump are left in place deliberately, so that the ignore rules are exercised.

// File: rtl/obl_pkg.sv
`timescale 1ns/1ps
package obl_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_LIVE = 2'd1,
    MODE_DUMP = 2'd2
  } obl_mode_e;

  typedef enum logic [1:0] {
    OP_HOLD     = 2'd0,
    OP_CLEAR    = 2'd1,
    OP_COMPRESS = 2'd2,
    OP_SHIFT    = 2'd3
  } obl_op_e;

endpackage

// File: rtl/obl_mode_ctrl.sv
`timescale 1ns/1ps
module obl_mode_ctrl
  import obl_pkg::*;
#(
  parameter int unsigned WIDTH = 24
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clr,
  input  logic    comp_on,
  input  logic    comp_off,
  input  logic    snap_go,
  input  logic    scan_en,
  output obl_op_e op,
  output logic    live,
  output logic    dumping
);

  localparam int unsigned CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  obl_mode_e     mode_q;
  logic [CW-1:0] cnt_q;

  // operation applied to the register this cycle
  always_comb begin
    if (clr)                                 op = OP_CLEAR;
    else if (mode_q == MODE_DUMP)            op = OP_SHIFT;
    else if (snap_go || mode_q == MODE_LIVE) op = OP_COMPRESS;
    else if (scan_en)                        op = OP_SHIFT;
    else                                     op = OP_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_IDLE;
      cnt_q  <= '0;
    end else begin
      unique case (mode_q)
        MODE_IDLE: begin
          if (snap_go) begin
            mode_q <= MODE_DUMP;
            cnt_q  <= '0;
          end else if (comp_on) begin
            mode_q <= MODE_LIVE;
          end
        end
        MODE_LIVE: begin
          if (snap_go) begin
            mode_q <= MODE_DUMP;
            cnt_q  <= '0;
          end else if (comp_off) begin
            mode_q <= MODE_IDLE;
          end
        end
        MODE_DUMP: begin
          if (cnt_q == LAST) begin
            mode_q <= MODE_IDLE;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: mode_q <= MODE_IDLE;
      endcase
    end
  end

  assign live    = (mode_q == MODE_LIVE);
  assign dumping = (mode_q == MODE_DUMP);

endmodule

// File: rtl/obl_sig_reg.sv
`timescale 1ns/1ps
module obl_sig_reg
  import obl_pkg::*;
#(
  parameter int unsigned       WIDTH = 24,
  parameter logic [WIDTH-1:0]  TAPS  = 24'hC20001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  obl_op_e          op,
  input  logic [WIDTH-1:0] nodes,
  input  logic             scan_in,
  output logic [WIDTH-1:0] sig,
  output logic             fb
);

  // next value of one stage for the chosen operation
  function automatic logic stage_next(obl_op_e o, logic cur, logic below_c,
                                      logic below_s, logic node, logic fb_tap);
    logic r;
    unique case (o)
      OP_HOLD:     r = cur;
      OP_CLEAR:    r = 1'b0;
      OP_COMPRESS: r = below_c ^ node ^ fb_tap;
      OP_SHIFT:    r = below_s;
      default:     r = cur;
    endcase
    return r;
  endfunction

  logic [WIDTH-1:0] sig_q;
  logic [WIDTH-1:0] sig_d;

  assign fb = sig_q[WIDTH-1];

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic below_c;
    logic below_s;
    if (i == 0) begin : g_first
      assign below_c = 1'b0;
      assign below_s = scan_in;
    end else begin : g_rest
      assign below_c = sig_q[i-1];
      assign below_s = sig_q[i-1];
    end
    assign sig_d[i] = stage_next(op, sig_q[i], below_c, below_s, nodes[i],
                                 fb & TAPS[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= '0;
    else        sig_q <= sig_d;
  end

  assign sig = sig_q;

endmodule

// File: rtl/obl_sig_chain.sv
`timescale 1ns/1ps
module obl_sig_chain
  import obl_pkg::*;
#(
  parameter int unsigned      WIDTH = 24,
  parameter logic [WIDTH-1:0] TAPS  = 24'hC20001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             comp_on,
  input  logic             comp_off,
  input  logic             snap_go,
  input  logic             scan_en,
  input  logic             scan_in,
  input  logic [WIDTH-1:0] nodes,
  output logic             scan_out,
  output logic             scan_vld,
  output logic             q_bit,
  output logic             q_vld
);

  obl_op_e          op;
  logic             live;
  logic             dumping;
  logic [WIDTH-1:0] sig_q;
  logic             fb;

  obl_mode_ctrl #(.WIDTH(WIDTH)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .comp_on  (comp_on),
    .comp_off (comp_off),
    .snap_go  (snap_go),
    .scan_en  (scan_en),
    .op       (op),
    .live     (live),
    .dumping  (dumping)
  );

  obl_sig_reg #(.WIDTH(WIDTH), .TAPS(TAPS)) i_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .nodes   (nodes),
    .scan_in (scan_in),
    .sig     (sig_q),
    .fb      (fb)
  );

  assign scan_out = sig_q[WIDTH-1];
  assign scan_vld = dumping;
  assign q_vld    = live;
  assign q_bit    = live & fb;

endmodule

// File: rtl/obl_sig_chain_chk.sv
`timescale 1ns/1ps
module obl_sig_chain_chk #(
  parameter int unsigned WIDTH = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             comp_off,
  input logic             snap_go,
  input logic             scan_en,
  input logic             scan_out,
  input logic             scan_vld,
  input logic             q_vld,
  input logic [WIDTH-1:0] sig
);

  localparam int unsigned RW = $clog2(WIDTH + 1);

  logic [RW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_len <= '0;
    else if (scan_vld) run_len <= run_len + 1'b1;
    else               run_len <= '0;
  end

  // R2
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sig == '0));

  // R6
  dump_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_vld |-> (run_len < RW'(WIDTH)));

  // R6
  dump_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_len != '0 && run_len < RW'(WIDTH)) |-> scan_vld);

  // R6
  dump_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_vld) |-> $past(snap_go));

  // R7
  dump_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_vld && $past(scan_vld) && !$past(clr)) |-> (scan_out == $past(sig[WIDTH-2])));

  // R5
  mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_vld && scan_vld));

  // R4
  live_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_vld && comp_off && !snap_go) |=> !q_vld);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_vld && !scan_vld && !snap_go && !scan_en && !clr) |=> $stable(sig));

endmodule

bind obl_sig_chain obl_sig_chain_chk #(.WIDTH(WIDTH)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr      (clr),
  .comp_off (comp_off),
  .snap_go  (snap_go),
  .scan_en  (scan_en),
  .scan_out (scan_out),
  .scan_vld (scan_vld),
  .q_vld    (q_vld),
  .sig      (sig_q)
);

// File: tb/test_obl_sig_chain.sv
`timescale 1ns/1ps
module test_obl_sig_chain;

  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clr = 1'b0, comp_on = 1'b0, comp_off = 1'b0;
  logic         snap_go = 1'b0, scan_en = 1'b0, scan_in = 1'b0;
  logic [W-1:0] nodes = '0;
  logic         scan_out, scan_vld, q_bit, q_vld;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // bench model: 0 idle, 1 compressing, 2 dumping
  logic [W-1:0] m_sig = '0;
  int           m_mode = 0;
  int           m_cnt = 0;

  always #10 clk = ~clk;

  obl_sig_chain i_obl_sig_chain (
    .clk(clk), .rst_n(rst_n), .clr(clr), .comp_on(comp_on), .comp_off(comp_off),
    .snap_go(snap_go), .scan_en(scan_en), .scan_in(scan_in), .nodes(nodes),
    .scan_out(scan_out), .scan_vld(scan_vld), .q_bit(q_bit), .q_vld(q_vld)
  );

  // division by x^24+x^23+x^22+x^17+1: exponents below 24 name the tap stages
  function automatic logic [W-1:0] bm_fold(logic [W-1:0] s, logic [W-1:0] n);
    logic [W-1:0] r;
    int exps[4] = '{23, 22, 17, 0};
    r = (s << 1) ^ n;
    if (s[W-1]) begin
      foreach (exps[k]) r[exps[k]] = ~r[exps[k]];
    end
    return r;
  endfunction

  function automatic logic [W-1:0] bm_shift(logic [W-1:0] s, logic b);
    return {s[W-2:0], b};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    if (clr) m_sig = '0;
    else if (m_mode == 2) m_sig = bm_shift(m_sig, scan_in);
    else if (snap_go || m_mode == 1) m_sig = bm_fold(m_sig, nodes);
    else if (scan_en) m_sig = bm_shift(m_sig, scan_in);
    if (m_mode == 2) begin
      if (m_cnt == W - 1) begin m_mode = 0; m_cnt = 0; end
      else m_cnt++;
    end else if (snap_go) begin
      m_mode = 2; m_cnt = 0;
    end else if (m_mode == 0 && comp_on) m_mode = 1;
    else if (m_mode == 1 && comp_off) m_mode = 0;
  endtask

  // called at a falling edge with inputs set; returns at the next falling edge after checking
  task automatic cyc(string tag);
    model_step();
    @(negedge clk);
    chk(tag, "scan_out", 32'(scan_out), 32'(m_sig[W-1]));
    chk("R6", "scan_vld", 32'(scan_vld), 32'(m_mode == 2));
    chk("R5", "q_vld", 32'(q_vld), 32'(m_mode == 1));
    chk("R5", "q_bit", 32'(q_bit), 32'((m_mode == 1) & m_sig[W-1]));
  endtask

  task automatic quiet();
    clr = 0; comp_on = 0; comp_off = 0; snap_go = 0; scan_en = 0; scan_in = 0;
  endtask

  // read back the register through a snapshot with zero nodes
  task automatic dump_word(output logic [W-1:0] w, input string tag);
    quiet(); nodes = '0; snap_go = 1;
    cyc(tag);
    snap_go = 0;
    for (int k = W - 1; k >= 0; k--) begin
      w[k] = scan_out;
      cyc(tag);
    end
  endtask

  initial begin
    logic [W-1:0] got;
    void'($urandom(32'h0B15EED));
    repeat (3) @(negedge clk);
    // R1: outputs during and right after reset
    chk("R1", "scan_out", 32'(scan_out), 0);
    chk("R1", "scan_vld", 32'(scan_vld), 0);
    chk("R1", "q_vld", 32'(q_vld), 0);
    chk("R1", "q_bit", 32'(q_bit), 0);
    rst_n = 1'b1;
    dump_word(got, "R1");
    chk("R1", "register after reset", 32'(got), 0);

    // R8: manual shift of a single one, nodes toggling randomly (ignored)
    quiet(); scan_en = 1;
    for (int k = 0; k < W; k++) begin
      scan_in = (k == 0); nodes = W'($urandom);
      cyc("R8");
    end
    // R10 and R3: snapshot with comp_on, nodes zero, from 0x800000 -> 0xC20001
    quiet(); nodes = '0; snap_go = 1; comp_on = 1;
    cyc("R10");
    quiet();
    for (int k = W - 1; k >= 0; k--) begin
      got[k] = scan_out;
      // R7: requests during dump have no effect
      comp_on = 1'($urandom); comp_off = 1'($urandom); snap_go = 1'($urandom);
      scan_en = 1'($urandom); nodes = W'($urandom); scan_in = 1'b0;
      cyc("R7");
    end
    chk("R3", "snapshot of 0x800000", 32'(got), 32'h00C20001);
    chk("R10", "idle after dump", 32'(q_vld), 0);

    // R9: idle hold with nodes moving
    quiet();
    for (int k = 0; k < 20; k++) begin nodes = W'($urandom); cyc("R9"); end

    // R2: clr together with snap_go and scan_en
    quiet(); clr = 1; snap_go = 1; scan_en = 1; scan_in = 1; nodes = '1;
    cyc("R2");
    quiet();
    for (int k = 0; k < W; k++) cyc("R2");

    // R4 and R5: on-line compression with random nodes
    quiet(); comp_on = 1; cyc("R4");
    quiet();
    for (int k = 0; k < 60; k++) begin
      nodes = W'($urandom); comp_on = 1'($urandom);
      cyc("R5");
    end
    comp_off = 1; comp_on = 0; cyc("R4");
    quiet(); cyc("R4");
    chk("R4", "compression stopped", 32'(q_vld), 0);

    // random mix
    for (int k = 0; k < 6000; k++) begin
      clr      = ($urandom_range(63) == 0);
      comp_on  = ($urandom_range(15) == 0);
      comp_off = ($urandom_range(15) == 0);
      snap_go  = ($urandom_range(31) == 0);
      scan_en  = ($urandom_range(2) == 0);
      scan_in  = 1'($urandom);
      nodes    = W'($urandom);
      cyc("R3");
    end
    quiet();
    repeat (W + 2) cyc("R6");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule